// File: doc/BRIEF.md
# Quadrature and Index Counter

This block tracks the position of up to four rotary or linear encoders. Each channel takes an A/B quadrature pair and an index line. It keeps a 16-bit position count and a 16-bit count of index events. A control word decides, per channel, whether the A/B pair is decoded and whether index events are counted. It also chooses which edge of the index line counts. A channel with decoding switched off falls back to a simple mode. Its position counter then climbs by one on every clock, and its index counter counts every edge of the index line. Software can use this mode as a timebase and an edge tally.

Every pin passes through a two-stage synchroniser before it is used. The counts, the control word and the synchronised pin levels are read through a small synchronous read port. A read is requested with an address and answered one cycle later with a valid strobe. The control word is loaded through a single write strobe. The counters can only be cleared by reset and cannot be written.

Top module: `quad_index_counter`

## Requirements
- R1: After reset, every index counter, the control word and the pin status word read as zero.
- R2: A cycle with `cfg_we` high loads the control word from `cfg_wdata`. Bits 15-12 enable quadrature decoding, bits 11-8 select index polarity and bits 7-4 enable index counting, with the lowest bit of each group serving channel 0. Bits 3-0 are not stored and read back as zero at address 8.
- R3: With decoding enabled, each single-bit change of the synchronised {A,B} pair in the order 00, 10, 11, 01, 00 (A leading B) adds one to the position count, and each step in the reverse order subtracts one, modulo 2^16. Without a change the count holds.
- R4: With decoding disabled, the position count increases by exactly one on every clock and wraps from 0xFFFF to 0x0000.
- R5: With decoding enabled, a change of both A and B in the same sampled cycle leaves the position count unchanged.
- R6: With decoding and index counting enabled, polarity 0 adds one on each rising edge of the index line and polarity 1 adds one on each falling edge. The other edge adds nothing.
- R7: With index counting disabled, the index count holds whatever the index line does.
- R8: With decoding disabled and index counting enabled, both edges of the index line add one each, whatever the polarity bit.
- R9: A quadrature step and an index event on the same channel in the same cycle are both counted.
- R10: Address 9 returns the synchronised pin levels. Bit 8+2i is A of channel i, bit 9+2i is B of channel i and bits 7-0 are the general inputs.
- R11: A cycle with `rd_en` high returns, in the next cycle, the addressed word on `rd_data` with `rd_valid` high. Addresses 0-3 are position counts 0-3, addresses 4-7 are index counts 0-3, and addresses 10-15 return zero. `rd_valid` is low in any cycle that follows a cycle without `rd_en`.
- R12: Writing the control word does not change any counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quad_a | input | 4 | Encoder A lines, one per channel |
| quad_b | input | 4 | Encoder B lines, one per channel |
| index_in | input | 4 | Encoder index lines, one per channel |
| gpio_in | input | 8 | General input pins reported in the status word |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 16 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | High in the cycle after a read request |

## Verification
The position counter and the index counter of one channel can both update on the same clock edge, because they are fed from separate synchronised lines. The bench provokes this on channel 1 by moving B one Gray step forward and raising the index line at the same clock edge, so that both changes leave the synchroniser together. It judges the result by reading both counts afterwards: the position must be one above its previous value and the index count must be exactly one. A lost or doubled update in either counter shows as a mismatch.

// File: rtl/qic_pkg.sv
package qic_pkg;

   // Result of one decoder evaluation
   typedef enum logic [1:0] {
      QM_HOLD = 2'd0,
      QM_INC  = 2'd1,
      QM_DEC  = 2'd2
   } qmove_e;

   // Per-channel configuration slice taken from the control word
   typedef struct packed {
      logic qen;   // quadrature decode enable
      logic pol;   // index polarity: 0 rising, 1 falling
      logic ien;   // index count enable
   } chan_cfg_t;

endpackage

// File: rtl/qic_sync.sv
module qic_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("qic_sync: STAGES must be 2 or more");
   end
   if (W < 1) begin : g_bad_width
      $error("qic_sync: W must be positive");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/qic_dec.sv
module qic_dec
   import qic_pkg::*;
(
   input  logic   a_now,
   input  logic   b_now,
   input  logic   a_was,
   input  logic   b_was,
   output qmove_e move
);

   logic a_chg;
   logic b_chg;

   assign a_chg = a_now ^ a_was;
   assign b_chg = b_now ^ b_was;

   // Exactly one line moved: a legal Gray step. Direction follows
   // whether the new A differs from the old B.
   always_comb begin
      move = QM_HOLD;
      if (a_chg ^ b_chg) begin
         move = (a_now ^ b_was) ? QM_INC : QM_DEC;
      end
   end

endmodule

// File: rtl/qic_chan.sv
module qic_chan
   import qic_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             a_s,
   input  logic             b_s,
   input  logic             idx_s,
   input  chan_cfg_t        cfg,
   output logic [CNT_W-1:0] pos,
   output logic [CNT_W-1:0] icnt
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("qic_chan: CNT_W must be 2 or more");
   end

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic   a_p, b_p, idx_p;
   qmove_e move;
   logic   idx_rise, idx_fall, idx_hit;

   qic_dec u_dec (
      .a_now (a_s),
      .b_now (b_s),
      .a_was (a_p),
      .b_was (b_p),
      .move  (move)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_p   <= 1'b0;
         b_p   <= 1'b0;
         idx_p <= 1'b0;
      end else begin
         a_p   <= a_s;
         b_p   <= b_s;
         idx_p <= idx_s;
      end
   end

   assign idx_rise = idx_s & ~idx_p;
   assign idx_fall = ~idx_s & idx_p;

   // Polarity picks an edge of the raw line, so a polarity change
   // alone never produces a count.
   always_comb begin
      if (cfg.qen) idx_hit = cfg.pol ? idx_fall : idx_rise;
      else         idx_hit = idx_rise | idx_fall;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (!cfg.qen) begin
         pos <= pos + ONE;
      end else begin
         case (move)
            QM_INC:  pos <= pos + ONE;
            QM_DEC:  pos <= pos - ONE;
            default: pos <= pos;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 icnt <= '0;
      else if (cfg.ien && idx_hit) icnt <= icnt + ONE;
   end

   // R4
   free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.qen |=> pos == $past(pos) + ONE);

   // R3
   step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.qen |=> (pos == $past(pos)) || (pos == $past(pos) + ONE)
                  || (pos == $past(pos) - ONE));

   // R5
   illegal_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.qen && (a_s != a_p) && (b_s != b_p) |=> $stable(pos));

   // R7
   idx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.ien |=> $stable(icnt));

   // R6
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.ien |=> (icnt == $past(icnt)) || (icnt == $past(icnt) + ONE));

endmodule

// File: rtl/quad_index_counter.sv
module quad_index_counter
   import qic_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int CNT_W       = 16,
   parameter int DATA_W      = 16,
   parameter int GPIO_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = $clog2(2*NUM_CH + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] quad_a,
   input  logic [NUM_CH-1:0] quad_b,
   input  logic [NUM_CH-1:0] index_in,
   input  logic [GPIO_W-1:0] gpio_in,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   localparam int SYNC_W    = 3*NUM_CH + GPIO_W;
   localparam int IEN_LSB   = NUM_CH;
   localparam int POL_LSB   = 2*NUM_CH;
   localparam int QEN_LSB   = 3*NUM_CH;
   localparam int A_ICNT    = NUM_CH;
   localparam int A_CTRL    = 2*NUM_CH;
   localparam int A_STAT    = 2*NUM_CH + 1;
   localparam int STAT_ALSB = GPIO_W;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("quad_index_counter: NUM_CH must be positive");
   end
   if (4*NUM_CH > DATA_W) begin : g_bad_ctrl
      $error("quad_index_counter: control fields exceed DATA_W");
   end
   if (2*NUM_CH + GPIO_W > DATA_W) begin : g_bad_stat
      $error("quad_index_counter: status fields exceed DATA_W");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("quad_index_counter: CNT_W exceeds DATA_W");
   end
   if ((1 << ADDR_W) < A_STAT + 1) begin : g_bad_addr
      $error("quad_index_counter: ADDR_W too narrow for the map");
   end

   // ---------------- synchroniser ----------------
   logic [SYNC_W-1:0] raw_in, syn_in;
   logic [NUM_CH-1:0] a_s, b_s, idx_s;
   logic [GPIO_W-1:0] gpio_s;

   assign raw_in = {gpio_in, index_in, quad_b, quad_a};

   qic_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign a_s    = syn_in[0        +: NUM_CH];
   assign b_s    = syn_in[NUM_CH   +: NUM_CH];
   assign idx_s  = syn_in[2*NUM_CH +: NUM_CH];
   assign gpio_s = syn_in[3*NUM_CH +: GPIO_W];

   // ---------------- control word ----------------
   logic [NUM_CH-1:0] qen_q, pol_q, ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qen_q <= '0;
         pol_q <= '0;
         ien_q <= '0;
      end else if (cfg_we) begin
         qen_q <= cfg_wdata[QEN_LSB +: NUM_CH];
         pol_q <= cfg_wdata[POL_LSB +: NUM_CH];
         ien_q <= cfg_wdata[IEN_LSB +: NUM_CH];
      end
   end

   logic [DATA_W-1:0] ctrl_word;
   always_comb begin
      ctrl_word = '0;
      ctrl_word[QEN_LSB +: NUM_CH] = qen_q;
      ctrl_word[POL_LSB +: NUM_CH] = pol_q;
      ctrl_word[IEN_LSB +: NUM_CH] = ien_q;
   end

   // ---------------- channels ----------------
   logic [CNT_W-1:0]  pos_arr  [NUM_CH];
   logic [CNT_W-1:0]  icnt_arr [NUM_CH];
   logic [DATA_W-1:0] stat_word;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      chan_cfg_t ch_cfg;
      assign ch_cfg.qen = qen_q[i];
      assign ch_cfg.pol = pol_q[i];
      assign ch_cfg.ien = ien_q[i];

      qic_chan #(.CNT_W(CNT_W)) u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .a_s   (a_s[i]),
         .b_s   (b_s[i]),
         .idx_s (idx_s[i]),
         .cfg   (ch_cfg),
         .pos   (pos_arr[i]),
         .icnt  (icnt_arr[i])
      );
   end

   always_comb begin
      stat_word = '0;
      stat_word[GPIO_W-1:0] = gpio_s;
      for (int i = 0; i < NUM_CH; i++) begin
         stat_word[STAT_ALSB + 2*i]     = a_s[i];
         stat_word[STAT_ALSB + 2*i + 1] = b_s[i];
      end
   end

   // ---------------- read port ----------------
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rd_addr == ADDR_W'(i))          rd_mux = DATA_W'(pos_arr[i]);
         if (rd_addr == ADDR_W'(A_ICNT + i)) rd_mux = DATA_W'(icnt_arr[i]);
      end
      if (rd_addr == ADDR_W'(A_CTRL)) rd_mux = ctrl_word;
      if (rd_addr == ADDR_W'(A_STAT)) rd_mux = stat_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= rd_mux;
      end
   end

   // R11
   rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   // R11
   rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   // R11
   rd_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && (rd_addr > ADDR_W'(A_STAT)) |=> rd_data == '0);

   // R2
   ctrl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && (rd_addr == ADDR_W'(A_CTRL)) |=> rd_data[NUM_CH-1:0] == '0);

endmodule

// File: tb/quad_index_counter_bench.sv
module quad_index_counter_bench;

   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYC    = 200000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  quad_a, quad_b, index_in;
   logic [7:0]  gpio_in;
   logic        cfg_we;
   logic [15:0] cfg_wdata;
   logic        rd_en;
   logic [3:0]  rd_addr;
   logic [15:0] rd_data;
   logic        rd_valid;

   always #(CLK_PERIOD/2) clk = ~clk;

   quad_index_counter u_quad_index_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .quad_a    (quad_a),
      .quad_b    (quad_b),
      .index_in  (index_in),
      .gpio_in   (gpio_in),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid)
   );

   typedef struct {
      logic [15:0] exp;
      bit          chk;
      string       tag;
   } item_t;

   item_t       sbq [$];
   int          checks = 0;
   int          errors = 0;
   logic [15:0] last_raw = '0;
   bit          done = 0;

   // Monitor: pops one expected item per returned read
   always @(negedge clk) begin : monitor
      item_t it;
      if (rst_n === 1'b1 && rd_valid === 1'b1) begin
         if (sbq.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R11: stray rd_valid actual %h expected no response", rd_data);
         end else begin
            it = sbq.pop_front();
            last_raw = rd_data;
            if (it.chk) begin
               checks++;
               if (rd_data !== it.exp) begin
                  errors++;
                  $display("FAIL %s: actual %h expected %h", it.tag, rd_data, it.exp);
               end
            end
         end
      end
   end

   task automatic issue(input logic [3:0] addr, input logic [15:0] exp,
                        input bit chk, input string tag);
      item_t it;
      it.exp = exp;
      it.chk = chk;
      it.tag = tag;
      @(negedge clk);
      sbq.push_back(it);
      rd_en   = 1'b1;
      rd_addr = addr;
      @(negedge clk);
      rd_en = 1'b0;
      #1;
   endtask

   task automatic expect_rd(input logic [3:0] addr, input logic [15:0] exp,
                            input string tag);
      issue(addr, exp, 1'b1, tag);
   endtask

   task automatic raw_rd(input logic [3:0] addr, output logic [15:0] v);
      issue(addr, 16'h0, 1'b0, "");
      v = last_raw;
   endtask

   task automatic write_cfg(input logic [15:0] v);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic set_ab(input int ch, input logic a, input logic b);
      @(negedge clk);
      quad_a[ch] = a;
      quad_b[ch] = b;
      settle();
   endtask

   task automatic set_idx(input int ch, input logic v);
      @(negedge clk);
      index_in[ch] = v;
      settle();
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin : watchdog
      repeat (MAX_CYC) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", MAX_CYC);
         report();
         $finish;
      end
   end

   initial begin : driver
      logic [15:0] v;
      logic [15:0] p0, p1, p2;
      rst_n     = 1'b0;
      quad_a    = '0;
      quad_b    = '0;
      index_in  = '0;
      gpio_in   = '0;
      cfg_we    = 1'b0;
      cfg_wdata = '0;
      rd_en     = 1'b0;
      rd_addr   = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      for (int i = 0; i < 4; i++) expect_rd(4'(4 + i), 16'h0000, "R1 index count");
      expect_rd(4'd8, 16'h0000, "R1 control");
      expect_rd(4'd9, 16'h0000, "R1 status");

      // R4: free-running count, two cycles between samples
      raw_rd(4'd0, v);
      expect_rd(4'd0, v + 16'd2, "R4 free run");
      // R4: long wait crossing the 16-bit wrap
      raw_rd(4'd1, v);
      repeat (70000) @(negedge clk);
      expect_rd(4'd1, v + 16'(70002), "R4 wrap");

      // R2: quad on for all, pol on ch2, index on ch0-2, low nibble dropped
      write_cfg(16'hF47F);
      expect_rd(4'd8, 16'hF470, "R2 control readback");
      settle();
      raw_rd(4'd0, p0);
      raw_rd(4'd1, p1);
      raw_rd(4'd2, p2);
      expect_rd(4'd0, p0, "R3 hold without input change");

      // R12: control write leaves counts alone
      write_cfg(16'hF47F);
      settle();
      expect_rd(4'd0, p0, "R12 pos after control write");
      expect_rd(4'd4, 16'h0000, "R12 index after control write");

      // R3: forward cycle on ch0
      set_ab(0, 1'b1, 1'b0);
      set_ab(0, 1'b1, 1'b1);
      set_ab(0, 1'b0, 1'b1);
      set_ab(0, 1'b0, 1'b0);
      expect_rd(4'd0, p0 + 16'd4, "R3 forward");
      // R3: reverse steps on ch1
      set_ab(1, 1'b0, 1'b1);
      set_ab(1, 1'b1, 1'b1);
      set_ab(1, 1'b1, 1'b0);
      expect_rd(4'd1, p1 - 16'd3, "R3 reverse");

      // R5: both lines jump on ch2
      set_ab(2, 1'b1, 1'b1);
      expect_rd(4'd2, p2, "R5 illegal 00->11");
      set_ab(2, 1'b0, 1'b0);
      expect_rd(4'd2, p2, "R5 illegal 11->00");

      // R6: ch0 counts rising edges
      set_idx(0, 1'b1);
      expect_rd(4'd4, 16'd1, "R6 rising pol0");
      set_idx(0, 1'b0);
      expect_rd(4'd4, 16'd1, "R6 falling pol0");
      // R6: ch2 counts falling edges
      set_idx(2, 1'b1);
      expect_rd(4'd6, 16'd0, "R6 rising pol1");
      set_idx(2, 1'b0);
      expect_rd(4'd6, 16'd1, "R6 falling pol1");

      // R7: ch3 index disabled
      set_idx(3, 1'b1);
      set_idx(3, 1'b0);
      expect_rd(4'd7, 16'd0, "R7 index disabled");

      // R9: ch1 at AB=10, step to 11 and raise index together
      @(negedge clk);
      quad_b[1]   = 1'b1;
      index_in[1] = 1'b1;
      settle();
      expect_rd(4'd1, p1 - 16'd2, "R9 pos with index");
      expect_rd(4'd5, 16'd1, "R9 index with step");
      set_idx(1, 1'b0);

      // R8: ch0 fallback, both edges counted
      write_cfg(16'hE470);
      set_idx(0, 1'b1);
      expect_rd(4'd4, 16'd2, "R8 fallback rise");
      set_idx(0, 1'b0);
      expect_rd(4'd4, 16'd3, "R8 fallback fall");

      // R10: pin levels
      @(negedge clk);
      quad_a  = 4'b0101;
      quad_b  = 4'b0011;
      gpio_in = 8'hA5;
      settle();
      expect_rd(4'd9, 16'h1BA5, "R10 status");

      // R11: unmapped addresses
      expect_rd(4'd10, 16'h0000, "R11 hole 10");
      expect_rd(4'd15, 16'h0000, "R11 hole 15");

      repeat (3) @(negedge clk);
      if (sbq.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL R11: actual %0d unanswered reads expected 0", sbq.size());
      end
      done = 1;
      report();
      $finish;
   end

endmodule